// File: doc/BRIEF.md
# Contact Card Power-Up Sequencer and Answer-to-Reset Supervisor

This block drives the four control lines of one contact card slot (supply enable, card clock, card reset and the I/O pull-down) through a cold power-up and an orderly power-down. It also times the card's first reply. A rising edge on the start control begins a power-up if a card sits in the slot and no fault is raised. The supply comes on first. After a settling wait the card clock starts, with reset held low. Reset is released after a selectable number of card clocks. From then on the slot counts as active.

While reset is low, and after it is released, a supervisor watches the card I/O input for its first falling edge. That edge is measured in card clock cycles against three programmable limits. The first limit is an early boundary, equal to a fixed base of 200 plus an offset. The second is a silence limit counted from reset release. The third is a silence limit counted during the reset-low hold. The supervisor raises sticky early and mute flags.

Clearing start, or raising any fault, winds the slot down. The lines fall in a fixed order, one step per spacing interval.

Top module: `card_act_seq`

## Requirements
- R1: Out of reset the supply enable, card clock, card reset and the active and flag outputs are all 0, and the I/O pull-down (io_low_o) is 1.
- R2: A power-up begins only on a 0-to-1 change of start_i while card_present_i is 1 and no fault is raised. A start that rises while the card is absent is ignored, and inserting the card afterwards with start still high does not begin a power-up.
- R3: The first card clock rising edge comes PWR_WAIT system cycles plus half a card period (SYS_PER_CC/2 system cycles) after the supply enable rises. No card clock runs, and the I/O stays pulled low, before that wait ends.
- R4: Card reset stays low for exactly N_ISO card clock rising edges when emv_mode_i is 0, and for N_EMV edges when it is 1. It then goes high.
- R5: active_o is 1 only while card reset is high, the supply is on and the I/O is released. It rises only if no fault was pending.
- R6: After reset release, a first I/O falling edge at fewer than 200 + early_ofs_i card clocks sets early_o only.
- R7: A first falling edge at or after the early limit and before t1_lim_i card clocks sets neither flag. Later silence does not set mute_o.
- R8: If no falling edge arrives within t1_lim_i card clocks of reset release, mute_o is set, early_o stays 0, and the slot stays active.
- R9: A falling edge on I/O while reset is still low sets both early_o and mute_o. A reset-low hold that lasts t3_lim_i card clocks sets mute_o.
- R10: Both flags hold their value until the next power-up begins, and they clear in the same cycle that the supply enable rises.
- R11: On power-down, card reset falls first. The card clock is held low STEP_GAP system cycles later, the I/O pull-down rises 2*STEP_GAP cycles later, and the supply turns off 3*STEP_GAP cycles later.
- R12: fault_i bit 0 (overheat), bit 1 (supply overcurrent) and bit 3 (converter overcurrent) abort any power-up or active phase into power-down. So does card_present_i going 0. Bit 2 (supply drop) does so only while auto_deact_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Power-up request level; its rising edge starts, and its low level stops |
| card_present_i | input | 1 | Debounced card presence, 1 = card in slot |
| fault_i | input | 4 | Fault inputs: 0 overheat, 1 supply overcurrent, 2 supply drop, 3 converter overcurrent |
| auto_deact_i | input | 1 | Lets the supply-drop fault trigger power-down |
| emv_mode_i | input | 1 | Selects the long reset hold (N_EMV) instead of N_ISO |
| early_ofs_i | input | OFS_W | Offset added to the 200-cycle early base |
| t1_lim_i | input | 16 | Silence limit after reset release, in card clocks |
| t3_lim_i | input | 16 | Silence limit during the reset-low hold, in card clocks |
| io_i | input | 1 | Sampled card I/O line |
| vcc_en_o | output | 1 | Card supply enable |
| card_clk_o | output | 1 | Card clock |
| card_rst_o | output | 1 | Card reset line level |
| io_low_o | output | 1 | 1 = drive card I/O low |
| active_o | output | 1 | Slot powered up with reset released |
| early_o | output | 1 | Sticky early-answer flag |
| mute_o | output | 1 | Sticky silence flag |

## Verification
The bench measures edge-to-edge distances on the card lines: supply rise to first clock, clock edges counted under reset, and the spacing of each power-down step. A sequencer off by one state would shift one of these counts.

It places the card's reply well inside each window: early, allowed, silent, and during the hold. A supervisor that compared against the wrong limit, kept timing after the first edge, or ignored edges under reset would show the wrong flag pair.

Three start cases target power-up gating: a start that rises while no card is present, a card inserted with start already high, and an overheat during the supply wait. Wrong gating would start a clock or leave the supply on. A supply-drop fault is applied with automatic power-down both disabled and enabled, which catches a fault mask left unconditional.

// File: rtl/card_act_pkg.sv
package card_act_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWRUP,
    ST_CLKRUN,
    ST_ACTIVE,
    ST_DRST,
    ST_DCLK,
    ST_DIO,
    ST_DVCC
  } seq_state_e;

  localparam int unsigned TMR_W          = 16;
  localparam int unsigned ATR_EARLY_BASE = 200;

  localparam int unsigned FLT_HEAT     = 0;
  localparam int unsigned FLT_VCC_OC   = 1;
  localparam int unsigned FLT_SUP_DROP = 2;
  localparam int unsigned FLT_DCDC_OC  = 3;
  localparam int unsigned FLT_N        = 4;

  function automatic logic [TMR_W-1:0] early_limit(input logic [TMR_W-1:0] ofs);
    return TMR_W'(ATR_EARLY_BASE) + ofs;
  endfunction

  function automatic logic fault_any(input logic present,
                                     input logic [FLT_N-1:0] flt,
                                     input logic auto_en);
    return !present | flt[FLT_HEAT] | flt[FLT_VCC_OC] | flt[FLT_DCDC_OC] |
           (flt[FLT_SUP_DROP] & auto_en);
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/card_clk_gen.sv
module card_clk_gen #(
  parameter int unsigned DIV = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic card_clk_o,
  output logic tick_o
);
  localparam int unsigned DW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);
  localparam logic [DW-1:0] HALF = DW'(DIV / 2);

  logic [DW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              phase_q <= '0;
    else if (!run_i)         phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                     phase_q <= phase_q + 1'b1;
  end

  assign card_clk_o = run_i && (phase_q >= HALF);
  assign tick_o     = run_i && (phase_q == LAST);
endmodule

// File: rtl/act_fsm.sv
module act_fsm
  import card_act_pkg::*;
#(
  parameter int unsigned PWR_WAIT = 542400,
  parameter int unsigned STEP_GAP = 27,
  parameter int unsigned N_ISO    = 400,
  parameter int unsigned N_EMV    = 40000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic card_present_i,
  input  logic fault_any_i,
  input  logic emv_i,
  input  logic tick_i,
  output logic vcc_en_o,
  output logic clk_run_o,
  output logic rst_o,
  output logic io_low_o,
  output logic active_o,
  output logic hold_o,
  output logic atr_o,
  output logic clear_o
);
  localparam int unsigned CW = $clog2(max4(PWR_WAIT, STEP_GAP, N_ISO, N_EMV) + 1);
  localparam logic [CW-1:0] PW_LAST   = CW'(PWR_WAIT - 1);
  localparam logic [CW-1:0] GAP_LAST  = CW'(STEP_GAP - 1);
  localparam logic [CW-1:0] ISO_LAST  = CW'(N_ISO - 1);
  localparam logic [CW-1:0] EMV_LAST  = CW'(N_EMV - 1);

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          start_q;
  logic          from_run_q;

  // named events used by the sequencer and visible to assertions
  logic          go;
  logic          abort;
  logic          gap_done;
  logic [CW-1:0] hold_last;

  assign go        = start_i && !start_q && card_present_i && !fault_any_i;
  assign abort     = !start_i || fault_any_i;
  assign gap_done  = (cnt_q == GAP_LAST);
  assign hold_last = emv_i ? EMV_LAST : ISO_LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      start_q    <= 1'b0;
      from_run_q <= 1'b0;
    end else begin
      start_q <= start_i;
      unique case (state_q)
        ST_IDLE: begin
          if (go) begin
            state_q    <= ST_PWRUP;
            cnt_q      <= '0;
            from_run_q <= 1'b0;
          end
        end
        ST_PWRUP: begin
          if (abort) begin
            state_q <= ST_DRST;
            cnt_q   <= '0;
          end else if (cnt_q == PW_LAST) begin
            state_q <= ST_CLKRUN;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_CLKRUN: begin
          if (abort) begin
            state_q    <= ST_DRST;
            cnt_q      <= '0;
            from_run_q <= 1'b1;
          end else if (tick_i) begin
            if (cnt_q == hold_last) begin
              state_q <= ST_ACTIVE;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_ACTIVE: begin
          if (abort) begin
            state_q    <= ST_DRST;
            cnt_q      <= '0;
            from_run_q <= 1'b1;
          end
        end
        ST_DRST: begin
          if (gap_done) begin state_q <= ST_DCLK; cnt_q <= '0; end
          else cnt_q <= cnt_q + 1'b1;
        end
        ST_DCLK: begin
          if (gap_done) begin state_q <= ST_DIO; cnt_q <= '0; end
          else cnt_q <= cnt_q + 1'b1;
        end
        ST_DIO: begin
          if (gap_done) begin state_q <= ST_DVCC; cnt_q <= '0; end
          else cnt_q <= cnt_q + 1'b1;
        end
        ST_DVCC: begin
          if (gap_done) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            from_run_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  always_comb begin
    vcc_en_o  = 1'b0;
    clk_run_o = 1'b0;
    rst_o     = 1'b0;
    io_low_o  = 1'b1;
    unique case (state_q)
      ST_IDLE:   ;
      ST_PWRUP:  vcc_en_o = 1'b1;
      ST_CLKRUN: begin vcc_en_o = 1'b1; clk_run_o = 1'b1; io_low_o = 1'b0; end
      ST_ACTIVE: begin vcc_en_o = 1'b1; clk_run_o = 1'b1; io_low_o = 1'b0; rst_o = 1'b1; end
      ST_DRST: begin
        vcc_en_o  = 1'b1;
        clk_run_o = from_run_q;
        io_low_o  = !from_run_q;
      end
      ST_DCLK: begin vcc_en_o = 1'b1; io_low_o = !from_run_q; end
      ST_DIO:    vcc_en_o = 1'b1;
      ST_DVCC:   ;
      default:   ;
    endcase
  end

  assign active_o = (state_q == ST_ACTIVE);
  assign hold_o   = (state_q == ST_CLKRUN);
  assign atr_o    = (state_q == ST_ACTIVE);
  assign clear_o  = (state_q == ST_IDLE) && go;
endmodule

// File: rtl/atr_mon.sv
module atr_mon
  import card_act_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             hold_i,
  input  logic             atr_i,
  input  logic             tick_i,
  input  logic             io_i,
  input  logic [TMR_W-1:0] early_lim_i,
  input  logic [TMR_W-1:0] t1_i,
  input  logic [TMR_W-1:0] t3_i,
  output logic             early_o,
  output logic             mute_o
);
  logic             io_q;
  logic             atr_q;
  logic [TMR_W-1:0] cnt_q;
  logic             done_q;

  logic io_fall;
  logic release_ev;
  logic timing;

  assign io_fall    = io_q && !io_i;
  assign release_ev = atr_i && !atr_q;
  assign timing     = hold_i || atr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_q  <= 1'b1;
      atr_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      io_q  <= io_i;
      atr_q <= atr_i;
      if (clear_i || !timing || release_ev) cnt_q <= '0;
      else if (tick_i && (cnt_q != {TMR_W{1'b1}})) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      early_o <= 1'b0;
      mute_o  <= 1'b0;
      done_q  <= 1'b0;
    end else if (clear_i) begin
      early_o <= 1'b0;
      mute_o  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (hold_i && !done_q) begin
        if (io_fall) begin
          early_o <= 1'b1;
          mute_o  <= 1'b1;
          done_q  <= 1'b1;
        end else if (cnt_q >= t3_i) begin
          mute_o <= 1'b1;
        end
      end
      if (atr_i && !release_ev && !done_q) begin
        if (io_fall) begin
          if (cnt_q < early_lim_i) early_o <= 1'b1;
          done_q <= 1'b1;
        end else if (cnt_q >= t1_i) begin
          mute_o <= 1'b1;
          done_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/card_act_seq.sv
module card_act_seq
  import card_act_pkg::*;
#(
  parameter int unsigned SYS_PER_CC = 6,
  parameter int unsigned PWR_WAIT   = 542400,
  parameter int unsigned STEP_GAP   = 27,
  parameter int unsigned N_ISO      = 400,
  parameter int unsigned N_EMV      = 40000,
  parameter int unsigned OFS_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             card_present_i,
  input  logic [3:0]       fault_i,
  input  logic             auto_deact_i,
  input  logic             emv_mode_i,
  input  logic [OFS_W-1:0] early_ofs_i,
  input  logic [15:0]      t1_lim_i,
  input  logic [15:0]      t3_lim_i,
  input  logic             io_i,
  output logic             vcc_en_o,
  output logic             card_clk_o,
  output logic             card_rst_o,
  output logic             io_low_o,
  output logic             active_o,
  output logic             early_o,
  output logic             mute_o
);
  logic clk_run;
  logic tick;
  logic hold;
  logic atr;
  logic clear;
  logic flt;
  logic [TMR_W-1:0] early_lim;

  assign flt       = fault_any(card_present_i, fault_i, auto_deact_i);
  assign early_lim = early_limit(TMR_W'(early_ofs_i));

  card_clk_gen #(.DIV(SYS_PER_CC)) u_clk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (clk_run),
    .card_clk_o (card_clk_o),
    .tick_o     (tick)
  );

  act_fsm #(
    .PWR_WAIT (PWR_WAIT),
    .STEP_GAP (STEP_GAP),
    .N_ISO    (N_ISO),
    .N_EMV    (N_EMV)
  ) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .card_present_i (card_present_i),
    .fault_any_i    (flt),
    .emv_i          (emv_mode_i),
    .tick_i         (tick),
    .vcc_en_o       (vcc_en_o),
    .clk_run_o      (clk_run),
    .rst_o          (card_rst_o),
    .io_low_o       (io_low_o),
    .active_o       (active_o),
    .hold_o         (hold),
    .atr_o          (atr),
    .clear_o        (clear)
  );

  atr_mon u_mon (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (clear),
    .hold_i      (hold),
    .atr_i       (atr),
    .tick_i      (tick),
    .io_i        (io_i),
    .early_lim_i (early_lim),
    .t1_i        (t1_lim_i),
    .t3_i        (t3_lim_i),
    .early_o     (early_o),
    .mute_o      (mute_o)
  );
endmodule

// File: rtl/card_act_seq_chk.sv
module card_act_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       card_present_i,
  input logic       vcc_en_o,
  input logic       card_clk_o,
  input logic       card_rst_o,
  input logic       io_low_o,
  input logic       active_o,
  input logic       early_o,
  input logic       mute_o
);
  a_r5_active_lines: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> (card_rst_o && vcc_en_o && !io_low_o));

  a_r3_clock_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
    card_clk_o |-> (vcc_en_o && !io_low_o));

  a_r10_flags_clear_at_powerup: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(early_o) || $fell(mute_o)) |-> $rose(vcc_en_o));

  a_r11_supply_off_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vcc_en_o) |-> (io_low_o && !card_rst_o && !card_clk_o));

  a_r2_powerup_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vcc_en_o) |-> ($past(card_present_i) && $past(start_i)));

  a_r12_active_needs_card: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> ($past(card_present_i) && $past(start_i)));
endmodule

bind card_act_seq card_act_seq_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_i        (start_i),
  .card_present_i (card_present_i),
  .vcc_en_o       (vcc_en_o),
  .card_clk_o     (card_clk_o),
  .card_rst_o     (card_rst_o),
  .io_low_o       (io_low_o),
  .active_o       (active_o),
  .early_o        (early_o),
  .mute_o         (mute_o)
);

// File: tb/card_act_seq_tb.sv
module card_act_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 2;
  localparam int PW   = 10;
  localparam int GAP  = 3;
  localparam int NISO = 8;
  localparam int NEMV = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        card_present_i = 1'b1;
  logic [3:0]  fault_i = 4'b0;
  logic        auto_deact_i = 1'b0;
  logic        emv_mode_i = 1'b0;
  logic [7:0]  early_ofs_i = 8'd10;
  logic [15:0] t1_lim_i = 16'd300;
  logic [15:0] t3_lim_i = 16'd1000;
  logic        io_i = 1'b1;
  logic vcc_en_o, card_clk_o, card_rst_o, io_low_o, active_o, early_o, mute_o;

  card_act_seq #(
    .SYS_PER_CC(DIV), .PWR_WAIT(PW), .STEP_GAP(GAP), .N_ISO(NISO), .N_EMV(NEMV), .OFS_W(8)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .card_present_i(card_present_i),
    .fault_i(fault_i), .auto_deact_i(auto_deact_i), .emv_mode_i(emv_mode_i),
    .early_ofs_i(early_ofs_i), .t1_lim_i(t1_lim_i), .t3_lim_i(t3_lim_i), .io_i(io_i),
    .vcc_en_o(vcc_en_o), .card_clk_o(card_clk_o), .card_rst_o(card_rst_o),
    .io_low_o(io_low_o), .active_o(active_o), .early_o(early_o), .mute_o(mute_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    string tag;
    logic  e;
    logic  m;
    logic  a;
  } exp_t;

  exp_t q[$];
  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  int t_vcc = 0, lat = -1, hold_edges = 0, t_rstf = 0, t_iol = 0, t_vccf = 0;
  bit clk_seen = 0;
  logic clk_at_io = 1'b0;
  logic p_vcc = 1'b0, p_clk = 1'b0, p_rst = 1'b0, p_io = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  // line timing monitor
  initial forever begin
    @(negedge clk);
    if (vcc_en_o && !p_vcc) begin t_vcc = cyc; hold_edges = 0; clk_seen = 0; lat = -1; end
    if (card_clk_o && !p_clk) begin
      if (!clk_seen) lat = cyc - t_vcc;
      clk_seen = 1;
      if (!card_rst_o) hold_edges++;
    end
    if (!card_rst_o && p_rst) t_rstf = cyc;
    if (io_low_o && !p_io) begin t_iol = cyc; clk_at_io = card_clk_o; end
    if (!vcc_en_o && p_vcc) t_vccf = cyc;
    p_vcc = vcc_en_o; p_clk = card_clk_o; p_rst = card_rst_o; p_io = io_low_o;
  end

  // scoreboard comparator
  initial forever begin
    exp_t it;
    wait (q.size() > 0);
    it = q.pop_front();
    n_vec++;
    if ({early_o, mute_o, active_o} !== {it.e, it.m, it.a}) begin
      n_bad++;
      $display("FAIL %s: early/mute/active got %b%b%b exp %b%b%b",
               it.tag, early_o, mute_o, active_o, it.e, it.m, it.a);
    end
  end

  task automatic expect_flags(input string tag, input logic e, input logic m, input logic a);
    exp_t it;
    it.tag = tag; it.e = e; it.m = m; it.a = a;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d exp %0d", tag, got, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_act();
    @(negedge clk);
    start_i = 1'b1;
    for (int i = 0; i < 4000 && !active_o; i++) @(negedge clk);
  endtask

  task automatic stop_act();
    @(negedge clk);
    start_i = 1'b0;
    cycles(20);
  endtask

  task automatic io_pulse();
    io_i = 1'b0;
    cycles(2);
    io_i = 1'b1;
    cycles(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    cycles(4);
    rst_n = 1'b1;
    cycles(2);
    // R1 reset state
    expect_flags("R1 reset flags", 0, 0, 0);
    chk("R1 vcc", vcc_en_o, 0);
    chk("R1 clk", card_clk_o, 0);
    chk("R1 rst", card_rst_o, 0);
    chk("R1 io_low", io_low_o, 1);

    // R2 start ignored without card, also after insertion with start held
    card_present_i = 1'b0;
    start_i = 1'b1;
    cycles(30);
    chk("R2 no card start", vcc_en_o, 0);
    card_present_i = 1'b1;
    cycles(30);
    chk("R2 insert with start high", vcc_en_o, 0);
    start_i = 1'b0;
    cycles(3);

    // ISO power-up, answer inside allowed window
    run_act();
    chk("R3 supply to first clock", lat, PW + DIV/2);
    chk("R4 ISO hold edges", hold_edges, NISO);
    chk("R5 active after release", active_o, 1);
    cycles(250 * DIV);
    io_pulse();
    expect_flags("R7 answer in window", 0, 0, 1);
    cycles(200 * DIV);
    expect_flags("R7 no mute after answer", 0, 0, 1);
    stop_act();
    chk("R11 io low after rst", t_iol - t_rstf, 2 * GAP);
    chk("R11 vcc off after io", t_vccf - t_iol, GAP);
    chk("R11 clock low at io step", clk_at_io, 0);
    chk("R11 vcc off", vcc_en_o, 0);
    expect_flags("R11 inactive after stop", 0, 0, 0);

    // early answer
    run_act();
    cycles(100 * DIV);
    io_pulse();
    expect_flags("R6 early answer", 1, 0, 1);
    stop_act();
    expect_flags("R10 early sticky after stop", 1, 0, 0);

    // flags cleared at next power-up, then mute
    @(negedge clk);
    start_i = 1'b1;
    cycles(2);
    expect_flags("R10 cleared at power-up", 0, 0, 0);
    for (int i = 0; i < 4000 && !active_o; i++) @(negedge clk);
    cycles(320 * DIV);
    expect_flags("R8 silent card", 0, 1, 1);
    stop_act();

    // EMV hold, edge during reset low
    emv_mode_i = 1'b1;
    @(negedge clk);
    start_i = 1'b1;
    cycles(PW + DIV/2 + 20);
    chk("R9 still in hold", card_rst_o, 0);
    io_pulse();
    for (int i = 0; i < 4000 && !active_o; i++) @(negedge clk);
    chk("R4 EMV hold edges", hold_edges, NEMV);
    expect_flags("R9 edge under reset", 1, 1, 1);
    stop_act();
    emv_mode_i = 1'b0;

    // hold reaches T3 limit
    t3_lim_i = 16'd5;
    run_act();
    cycles(250 * DIV);
    io_pulse();
    expect_flags("R9 hold reaches t3", 0, 1, 1);
    stop_act();
    t3_lim_i = 16'd1000;

    // card removal while active
    run_act();
    @(negedge clk);
    card_present_i = 1'b0;
    cycles(20);
    chk("R12 removal vcc off", vcc_en_o, 0);
    chk("R12 removal order", t_iol - t_rstf, 2 * GAP);
    expect_flags("R12 removal inactive", 0, 0, 0);
    card_present_i = 1'b1;
    start_i = 1'b0;
    cycles(3);

    // supply drop masked, then enabled
    run_act();
    fault_i = 4'b0100;
    cycles(20);
    expect_flags("R12 drop masked", 0, 0, 1);
    auto_deact_i = 1'b1;
    cycles(20);
    chk("R12 drop enabled vcc", vcc_en_o, 0);
    expect_flags("R12 drop enabled", 0, 0, 0);
    fault_i = 4'b0;
    auto_deact_i = 1'b0;
    start_i = 1'b0;
    cycles(3);

    // overheat during supply wait
    @(negedge clk);
    start_i = 1'b1;
    cycles(4);
    fault_i = 4'b0001;
    cycles(30);
    chk("R12 overheat vcc", vcc_en_o, 0);
    chk("R12 overheat no clock", clk_seen, 0);
    expect_flags("R12 overheat inactive", 0, 0, 0);
    fault_i = 4'b0;
    start_i = 1'b0;
    cycles(5);

    wait (q.size() == 0);
    cycles(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule